// File: doc/BRIEF.md
# Level-Sensitive Interrupt Cause Aggregator

This block gathers fourteen active-high interrupt request levels from peripherals and turns them into one interrupt line for a CPU. Software reads a cause word that is a registered, live copy of the request levels. It cannot clear anything in that word. Each peripheral owns its own status bit, and writing that bit is what drops the request. A second word holds a mask: a source reaches the CPU only while its mask bit is set. Above the source bits, the cause word also carries the registered level of a reset-switch state input. That bit never raises the interrupt.

Access goes through a small 32-bit register bus with a byte address, a write strobe, a read strobe and data in both directions. Read data is combinational: it is valid in the same cycle as the read strobe and is zero when no read is in progress. The cause word is at offset 0x00 and the mask word at offset 0x04.

Top module: `irq_cause_agg`

## Requirements
- R1: Cause bits 0 to 13 show the levels of `src_req[13:0]` as sampled at the previous clock edge, in this bit order: graphics error, reset switch, disc, serial, external port, audio, DSP, memory, video, pixel token, pixel finish, command FIFO, debugger, high-speed port.
- R2: Cause bit 16 shows the level of `rst_state_in` as sampled at the previous clock edge.
- R3: Cause bits 14, 15 and 17 to 31 always read as zero.
- R4: A write to offset 0x00 changes no register; afterwards the cause and mask words read exactly as they would without the write.
- R5: A write to offset 0x04 loads mask bits 0 to 13 from `bus_wdata[13:0]` at the clock edge. Data bits 14 to 31 are ignored, and mask bits 14 to 31 read as zero.
- R6: After reset the mask word is zero and `cpu_irq` is low.
- R7: `cpu_irq` equals the OR over bits 0 to 13 of (cause AND mask). It is registered, so a change in a request or a mask write shows on `cpu_irq` one clock edge later, together with the register update.
- R8: The reset-state bit (cause bit 16) never asserts `cpu_irq`, whatever the mask holds.
- R9: `bus_rdata` is zero while `bus_rd` is low and for a read of any offset other than 0x00 or 0x04. A write to any other offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 14 | Active-high request level, one per source |
| rst_state_in | input | 1 | Reset-switch state level, reported in cause bit 16 |
| bus_addr | input | 4 | Byte offset into the register window |
| bus_wr | input | 1 | Write strobe, acted on at the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |
| cpu_irq | output | 1 | Registered interrupt toward the CPU |

## Verification
The bench walks a single request through every source position and checks the cause bit in that position. A design with a swapped or shifted bit order fails there. It writes all-ones to the cause offset and to unused offsets. A design that decodes the address loosely would corrupt the mask, which the bench then sees on readback or on the interrupt line. It writes all-ones to the mask, so a design that keeps the upper bits shows them on readback. With the reset-state input high and every mask bit set, the interrupt line must stay low. A design that folds bit 16 into the OR raises the interrupt. The bench also checks that the interrupt line follows a mask write after exactly one edge, and that the line drops when the request drops. A design with an extra pipeline stage fails these latency checks.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned IRQ_SRC_CNT  = 14;
    localparam int unsigned IRQ_DATA_W   = 32;
    localparam int unsigned IRQ_ADDR_W   = 4;
    localparam int unsigned IRQ_RSTB_POS = 16;
    localparam int unsigned IRQ_CAUSE_OFS = 0;
    localparam int unsigned IRQ_MASK_OFS  = 4;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
    parameter int unsigned NUM_SRC = 14,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned RST_POS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               rst_state_in,
    output logic [NUM_SRC-1:0] lvl_nxt,
    output logic [NUM_SRC-1:0] lvl_cur,
    output logic [DATA_W-1:0]  cause_word
);
    typedef struct packed {
        logic [NUM_SRC-1:0] lvl;
        logic               rst_lvl;
    } cause_st_t;

    cause_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.lvl     = src_req;
        st_d.rst_lvl = rst_state_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_nxt = st_d.lvl;
    assign lvl_cur = st_q.lvl;

    for (genvar b = 0; b < DATA_W; b++) begin : g_word
        if (b < NUM_SRC) begin : g_src
            assign cause_word[b] = st_q.lvl[b];
        end else if (b == RST_POS) begin : g_rst
            assign cause_word[b] = st_q.rst_lvl;
        end else begin : g_zero
            assign cause_word[b] = 1'b0;
        end
    end

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_cause_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (cause_word[NUM_SRC-1:0] == $past(src_req)));
    p_rst_bit_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (cause_word[RST_POS] == $past(rst_state_in)));
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause_word) == $countones(cause_word[NUM_SRC-1:0]) + (cause_word[RST_POS] ? 1 : 0));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned NUM_SRC = 14,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SRC-1:0] mask_nxt,
    output logic [NUM_SRC-1:0] mask_cur
);
    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.bits = wdata[NUM_SRC-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_nxt = st_d.bits;
    assign mask_cur = st_q.bits;

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_cur));
    p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_cur == $past(wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
    parameter int unsigned NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl_nxt,
    input  logic [NUM_SRC-1:0] mask_nxt,
    input  logic [NUM_SRC-1:0] lvl_cur,
    input  logic [NUM_SRC-1:0] mask_cur,
    output logic               irq_out
);
    typedef struct packed {
        logic irq;
    } comb_st_t;

    comb_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(lvl_nxt & mask_nxt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_out = st_q.irq;

    p_irq_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == ($countones(lvl_cur & mask_cur) != 0));
    p_irq_off_when_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_cur == '0) |-> !irq_out);
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC = IRQ_SRC_CNT,
    parameter int unsigned DATA_W  = IRQ_DATA_W,
    parameter int unsigned ADDR_W  = IRQ_ADDR_W,
    parameter int unsigned RST_POS = IRQ_RSTB_POS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               rst_state_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               cpu_irq
);
    localparam logic [ADDR_W-1:0] CAUSE_ADDR = ADDR_W'(IRQ_CAUSE_OFS);
    localparam logic [ADDR_W-1:0] MASK_ADDR  = ADDR_W'(IRQ_MASK_OFS);

    logic [NUM_SRC-1:0] lvl_nxt, lvl_cur, mask_nxt, mask_cur;
    logic [DATA_W-1:0]  cause_word;
    reg_sel_e           sel;
    logic               mask_wr;

    always_comb begin
        if (bus_addr == CAUSE_ADDR)     sel = SEL_CAUSE;
        else if (bus_addr == MASK_ADDR) sel = SEL_MASK;
        else                            sel = SEL_NONE;
    end

    assign mask_wr = bus_wr && (sel == SEL_MASK);

    irq_cause_reg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .RST_POS(RST_POS)) u_cause (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .rst_state_in(rst_state_in),
        .lvl_nxt(lvl_nxt), .lvl_cur(lvl_cur), .cause_word(cause_word)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(bus_wdata),
        .mask_nxt(mask_nxt), .mask_cur(mask_cur)
    );

    irq_combine #(.NUM_SRC(NUM_SRC)) u_comb (
        .clk(clk), .rst_n(rst_n), .lvl_nxt(lvl_nxt), .mask_nxt(mask_nxt),
        .lvl_cur(lvl_cur), .mask_cur(mask_cur), .irq_out(cpu_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_CAUSE: bus_rdata = cause_word;
                SEL_MASK:  bus_rdata = {{(DATA_W-NUM_SRC){1'b0}}, mask_cur};
                default:   bus_rdata = '0;
            endcase
        end
    end

    p_idle_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
    p_rst_bit_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_cur == '0) |-> !cpu_irq);
endmodule

// File: tb/irq_cause_agg_bench.sv
module irq_cause_agg_bench;
    localparam int NSRC = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] src_req = '0;
    logic        rst_state_in = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    irq_cause_agg u_irq_cause_agg (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .rst_state_in(rst_state_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    // monitor: compares read data against queued expectations
    always @(negedge clk) begin
        if (bus_rd && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (bus_rdata !== e.val) begin
                failures++;
                $display("FAIL %s rdata actual=%h expected=%h", e.tag, bus_rdata, e.val);
            end
        end
    end

    task automatic do_read(input logic [3:0] a, input logic [31:0] ev, input string tag);
        exp_t e;
        @(posedge clk); #2;
        bus_addr = a; bus_rd = 1'b1;
        e.val = ev; e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic chk(input logic act, input logic ex, input string tag);
        checks++;
        if (act !== ex) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, ex);
        end
    endtask

    task automatic set_src(input logic [13:0] v);
        @(posedge clk); #2;
        src_req = v;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R6: reset state
        #1 chk(cpu_irq, 1'b0, "R6 irq after reset");
        do_read(4'h4, 32'h0, "R6 mask after reset");
        do_read(4'h0, 32'h0, "R1 cause idle");

        // R1: walking request per source position
        for (int i = 0; i < NSRC; i++) begin
            set_src(14'(1 << i));
            do_read(4'h0, 32'h1 << i, "R1 walk");
        end
        set_src(14'h2A55);
        do_read(4'h0, 32'h0000_2A55, "R1 pattern");
        // R6: masked sources do not reach irq
        chk(cpu_irq, 1'b0, "R6 all masked");

        // R2 and R3
        rst_state_in = 1'b1;
        set_src(14'h3FFF);
        do_read(4'h0, 32'h0001_3FFF, "R2 R3 reset bit and zeros");

        // R4: write to cause offset ignored
        do_write(4'h0, 32'hFFFF_FFFF);
        do_read(4'h0, 32'h0001_3FFF, "R4 cause after write");
        do_read(4'h4, 32'h0, "R4 mask after cause write");
        chk(cpu_irq, 1'b0, "R4 irq after cause write");

        // R9: other offsets
        do_write(4'h8, 32'hFFFF_FFFF);
        do_read(4'h4, 32'h0, "R9 mask after stray write");
        do_read(4'h8, 32'h0, "R9 unused offset read");
        do_read(4'hC, 32'h0, "R9 unused offset read");

        // R5: mask upper bits dropped
        do_write(4'h4, 32'hFFFF_FFFF);
        do_read(4'h4, 32'h0000_3FFF, "R5 mask readback");

        // R8: only reset bit active, everything enabled
        set_src(14'h0);
        @(posedge clk); #3;
        chk(cpu_irq, 1'b0, "R8 reset bit no irq");
        rst_state_in = 1'b0;

        // R7: request latency
        set_src(14'h0100);
        chk(cpu_irq, 1'b0, "R7 irq before edge");
        @(posedge clk); #3;
        chk(cpu_irq, 1'b1, "R7 irq one edge after request");
        set_src(14'h0);
        @(posedge clk); #3;
        chk(cpu_irq, 1'b0, "R7 irq drops with request");

        // R7: mask write latency
        set_src(14'h0400);
        do_write(4'h4, 32'h0000_0001);
        chk(cpu_irq, 1'b0, "R7 masked other source");
        @(posedge clk); #2;
        bus_addr = 4'h4; bus_wdata = 32'h0000_0400; bus_wr = 1'b1;
        #1 chk(cpu_irq, 1'b0, "R7 irq before mask edge");
        @(posedge clk); #2;
        bus_wr = 1'b0;
        chk(cpu_irq, 1'b1, "R7 irq one edge after mask write");
        do_read(4'h4, 32'h0000_0400, "R5 mask single bit");

        // R5: ignore upper data bits only
        do_write(4'h4, 32'hFFFF_C000);
        do_read(4'h4, 32'h0, "R5 upper data ignored");
        chk(cpu_irq, 1'b0, "R7 irq off after mask clear");

        // R9: idle read data
        @(negedge clk);
        checks++;
        if (bus_rdata !== 32'h0) begin
            failures++;
            $display("FAIL R9 idle rdata actual=%h expected=%h", bus_rdata, 32'h0);
        end

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R9 unconsumed reads actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule